// File: doc/BRIEF.md
# Square-Wave Interval Counter

This block is a single programmable down-counter that produces a continuous square wave. Software loads a 16-bit initial count as two bytes through an 8-bit write port, low byte first. The counter takes the value on a later counter-clock pulse and drives its output high. From then on the output changes level every half-period, so one full period lasts the initial count times the counter clock period. With a counter clock near 1.19 MHz, each count step is about 838 ns.

The counter clock arrives as a one-cycle enable pulse in the system clock domain. The write port shares that clock. Internally the working count drops by two on each enabled pulse. When a half-period ends, the counter reloads a value derived from the latest complete count, so the output toggles on every reload. Odd counts are split unevenly between the two halves, and the total period is kept exact.

A gate input enables counting. In normal use it is held high.

Top module: `sqw_timer`

## Requirements
- R1: A synchronous reset forces the output high and returns the counter to an idle, unloaded state with the byte pointer on the low byte. While idle the output stays high, whatever counter pulses arrive.
- R2: A count is written as two bytes, low byte first (bits 7:0) and then the high byte (bits 15:8). The count is complete only after the high byte. A lone low byte starts nothing.
- R3: A completed count is loaded on the first enabled counter pulse after the cycle in which the high byte was written. A pulse in that same cycle does not load it. On loading, the output is high.
- R4: For an even count N, each output level lasts N/2 enabled pulses, so the period is N pulses.
- R5: For an odd count N, the high level lasts (N+1)/2 pulses and the low level lasts (N-1)/2 pulses.
- R6: A written count of zero acts as 65536, giving 32768 pulses per level.
- R7: A written count of one acts as two, so the output toggles on every enabled pulse.
- R8: A count written while the counter runs leaves the current half-period unchanged. The new count takes effect at the next reload.
- R9: While the gate input is low, counter pulses have no effect: the working count and the output hold.
- R10: Outside reset, the output changes only on a cycle with an enabled counter pulse. Between reloads the working count falls by exactly two per enabled pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock shared by the write port and the counter |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte being written (low byte first, then high byte) |
| cnt_en | input | 1 | One-cycle counter clock enable pulse |
| gate | input | 1 | Count enable; counting pauses while low |
| sq_out | output | 1 | Square-wave output |

## Verification
Two events can fall in the same cycle: a high-byte write that completes a count, and a counter pulse that would load or reload the counter. The bench drives the high-byte strobe and the counter pulse in the same cycle. It then counts the pulses until the first toggle, expecting one pulse more than half the count, because the load must wait for the following pulse. In the same way, a rewrite made partway through a half-period is judged by lengths: the current half must keep its old length, and the halves after it must follow the new count.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } run_phase_e;
endpackage

// File: rtl/sqw_wr_port.sv
module sqw_wr_port
    import sqw_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int CW = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              pend_valid,
    output logic [CW-1:0]     pend_val
);
    byte_ptr_e         ptr;
    logic [BYTE_W-1:0] lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= PTR_LO;
            lo_hold    <= '0;
            pend_valid <= 1'b0;
            pend_val   <= '0;
        end else begin
            if (take) pend_valid <= 1'b0;
            if (wr_en) begin
                if (ptr == PTR_LO) begin
                    lo_hold <= wr_data;
                    ptr     <= PTR_HI;
                end else begin
                    pend_val   <= {wr_data, lo_hold};
                    pend_valid <= 1'b1;
                    ptr        <= PTR_LO;
                end
            end
        end
    end
endmodule

// File: rtl/sqw_half_counter.sv
module sqw_half_counter
    import sqw_pkg::*;
#(
    parameter int CW = 2 * DEF_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          pend_valid,
    input  logic [CW-1:0] pend_val,
    output logic          take,
    output logic          out,
    output logic          loaded,
    output logic [CW:0]   count
);
    localparam logic [CW:0] TWO = (CW+1)'(2);
    localparam logic [CW:0] ONE = (CW+1)'(1);

    run_phase_e    phase;
    logic [CW-1:0] init;
    logic [CW-1:0] next_init;
    logic          at_end;

    function automatic logic [CW:0] half_len(input logic [CW-1:0] n, input logic high);
        logic [CW:0] e;
        e = (n == '0) ? (ONE << CW) : {1'b0, n};
        if (e == ONE) e = TWO;
        if (e[0]) e = high ? e + ONE : e - ONE;
        return e;
    endfunction

    assign loaded    = (phase == PH_RUN);
    assign at_end    = loaded && (count == TWO);
    assign take      = step && pend_valid && (!loaded || at_end);
    assign next_init = pend_valid ? pend_val : init;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            out   <= 1'b1;
            count <= '0;
            init  <= '0;
        end else if (step) begin
            if (!loaded) begin
                if (pend_valid) begin
                    init  <= pend_val;
                    count <= half_len(pend_val, 1'b1);
                    out   <= 1'b1;
                    phase <= PH_RUN;
                end
            end else if (at_end) begin
                init  <= next_init;
                out   <= ~out;
                count <= half_len(next_init, ~out);
            end else begin
                count <= count - TWO;
            end
        end
    end
endmodule

// File: rtl/sqw_timer.sv
module sqw_timer
    import sqw_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int CW = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cnt_en,
    input  logic              gate,
    output logic              sq_out
);
    logic          pend_valid;
    logic [CW-1:0] pend_val;
    logic          take;
    logic          loaded;
    logic [CW:0]   count;
    logic          step;

    assign step = cnt_en & gate;

    sqw_wr_port #(.BYTE_W(BYTE_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_val   (pend_val)
    );

    sqw_half_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .pend_valid (pend_valid),
        .pend_val   (pend_val),
        .take       (take),
        .out        (sq_out),
        .loaded     (loaded),
        .count      (count)
    );
endmodule

// File: rtl/sqw_timer_chk.sv
module sqw_timer_chk #(
    parameter int CW = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cnt_en,
    input logic        gate,
    input logic        sq_out,
    input logic        loaded,
    input logic [CW:0] count
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: output is high in the cycle after reset
    always @(posedge clk) begin
        if (rst_q === 1'b1) a_r1_reset_high: assert (sq_out === 1'b1);
    end

    // R1, R3: output high whenever idle
    a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> sq_out);

    // R4, R5: working count is even and at least two once loaded
    a_r4_count_even: assert property (@(posedge clk) disable iff (rst)
        loaded |-> (count[0] == 1'b0 && count >= (CW+1)'(2)));

    // R10: output holds without an enabled pulse
    a_r10_out_stable: assert property (@(posedge clk) disable iff (rst)
        !(cnt_en && gate) |=> $stable(sq_out));

    // R10: step of exactly two between reloads
    a_r10_step_two: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && gate && loaded && count > (CW+1)'(2)) |=>
            (count == $past(count) - (CW+1)'(2)) && $stable(sq_out));

    // R9: gate low freezes the count
    a_r9_gate_hold: assert property (@(posedge clk) disable iff (rst)
        !gate |=> $stable(count));
endmodule

bind sqw_timer sqw_timer_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .gate   (gate),
    .sq_out (sq_out),
    .loaded (loaded),
    .count  (count)
);

// File: tb/sqw_timer_test.sv
module sqw_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cnt_en = 1'b0;
    logic       gate = 1'b1;
    logic       sq_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sqw_timer uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt_en  (cnt_en),
        .gate    (gate),
        .sq_out  (sq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; cnt_en = 1'b0; gate = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] n);
        wr_byte(n[7:0]);
        wr_byte(n[15:8]);
    endtask

    task automatic tick();
        @(negedge clk);
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic measure_half(input int max, output int n);
        logic prev;
        prev = sq_out;
        n = 0;
        do begin
            tick();
            n++;
        end while (sq_out == prev && n < max);
    endtask

    task automatic t_reset();
        int stuck = 0;
        do_reset();
        check("R1 reset out", sq_out, 1);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (sq_out !== 1'b1) stuck++;
        end
        check("R1 idle no toggle", stuck, 0);
    endtask

    task automatic t_low_only();
        int n;
        int moved = 0;
        do_reset();
        wr_byte(8'h06);
        for (int i = 0; i < 10; i++) begin
            tick();
            if (sq_out !== 1'b1) moved++;
        end
        check("R2 low byte alone", moved, 0);
        wr_byte(8'h00);
        tick();
        measure_half(100, n);
        check("R2 low then high", n, 3);
    endtask

    task automatic t_run(input string req, input logic [15:0] cnt,
                         input int h, input int l);
        int n;
        do_reset();
        wr_count(cnt);
        tick();
        check({req, " loaded high"}, sq_out, 1);
        measure_half(40000, n);
        check({req, " high half"}, n, h);
        if (l > 0) begin
            measure_half(40000, n);
            check({req, " low half"}, n, l);
            measure_half(40000, n);
            check({req, " second high"}, n, h);
        end
    endtask

    task automatic t_rewrite();
        int n;
        do_reset();
        wr_count(16'd10);
        tick();
        tick();
        tick();
        wr_count(16'd6);
        measure_half(100, n);
        check("R8 current half kept", n, 3);
        measure_half(100, n);
        check("R8 new low half", n, 3);
        measure_half(100, n);
        check("R8 new high half", n, 3);
    endtask

    task automatic t_coincide();
        int n;
        do_reset();
        wr_byte(8'h08);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h00; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        check("R3 coincident out", sq_out, 1);
        measure_half(100, n);
        check("R3 load waits one pulse", n, 5);
    endtask

    task automatic t_gate();
        int n;
        int moved = 0;
        do_reset();
        wr_count(16'd8);
        tick();
        tick();
        gate = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (sq_out !== 1'b1) moved++;
        end
        check("R9 gate low holds", moved, 0);
        gate = 1'b1;
        measure_half(100, n);
        check("R9 resume remainder", n, 3);
    endtask

    task automatic t_reset_mid();
        int n;
        int moved = 0;
        do_reset();
        wr_count(16'd4);
        tick();
        measure_half(100, n);
        check("R4 reach low", sq_out, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", sq_out, 1);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (sq_out !== 1'b1) moved++;
        end
        check("R1 idle after reset", moved, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_low_only();
        t_run("R4 even 10", 16'd10, 5, 5);
        t_run("R5 odd 7", 16'd7, 4, 3);
        t_run("R7 one", 16'd1, 1, 1);
        t_run("R5 odd 3", 16'd3, 2, 1);
        t_rewrite();
        t_coincide();
        t_gate();
        t_reset_mid();
        t_run("R6 zero", 16'd0, 32768, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule